// File: doc/BRIEF.md
# Multi-Latency Execution Pool

This block models the execute stage of an out-of-order core at the level of timing only. Each cycle it takes up to `ISSUE_W` issued instructions, each described by a tag, a two-bit op code and an optional destination register. Every accepted instruction sits in a slot of a shared pool while a per-slot down-counter runs out the fixed latency of its op code. No operand values pass through the block.

When a counter runs out, the slot is freed. If the instruction names a destination, a completion record (tag and destination register) goes out on a wide completion port. The wakeup and register-status logic downstream use that record. The op codes have different latencies, so several instructions can finish in one cycle, and a young short op can finish before an old long one. The completion port has room for all of them: lanes are filled from lane 0 upward in ascending tag order.

The pool holds `ISSUE_W` times the longest latency in slots. That is the most that can be in flight when every cycle issues the full width of the longest op. A slot freed in a cycle can take a new instruction in that same cycle.

Top module: `epool_top`

## Requirements
- R1: A synchronous active-high reset empties the pool. During reset, and afterwards until a newly issued instruction finishes, every `doneValid` bit is 0. Instructions in flight when reset is applied never complete.
- R2: Op code 0 has a latency of one cycle. An instruction issued at clock edge k appears on the completion port in the cycle after edge k.
- R3: Op code 1 has a latency of two cycles. An instruction issued at edge k appears in the cycle after edge k+1, and not before.
- R4: Op code 2 has a latency of ten cycles. An instruction issued at edge k appears in the cycle after edge k+9, and not before.
- R5: Every valid issue lane is accepted, with no cap per op code. This holds when all `ISSUE_W` lanes issue op code 2 every cycle without a break, and every such instruction completes.
- R6: An instruction issued with `issueHasDest` = 0 never appears on the completion port. Its slot is still released when its latency ends, so a pool once filled with such instructions keeps accepting work at full rate.
- R7: Completions that fall in the same cycle occupy lanes 0 to m-1 of the port, with strictly ascending unsigned tags from lane 0 upward. All lanes from m upward have `doneValid` = 0.
- R8: When an instruction finishes depends only on its own issue edge and op code. A younger instruction with a shorter latency completes before an older one with a longer latency.
- R9: Completion lane k shows, at `doneTag[k*TAG_W +: TAG_W]` and `doneDest[k*REG_W +: REG_W]`, exactly the tag and destination issued with that instruction. Issue lane i reads its fields at `issueOp[2*i +: 2]`, `issueTag[i*TAG_W +: TAG_W]` and `issueDest[i*REG_W +: REG_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issueValid | input | ISSUE_W | One bit per issue lane: lane carries an instruction |
| issueOp | input | 2*ISSUE_W | Op code per lane (0, 1 or 2; 3 is reserved) |
| issueTag | input | ISSUE_W*TAG_W | Instruction tag per lane |
| issueDest | input | ISSUE_W*REG_W | Destination register per lane |
| issueHasDest | input | ISSUE_W | Lane's instruction writes a destination register |
| doneValid | output | 3*ISSUE_W | Completion lane holds a record |
| doneTag | output | 3*ISSUE_W*TAG_W | Tag per completion lane |
| doneDest | output | 3*ISSUE_W*REG_W | Destination register per completion lane |

## Verification
The assertions assume the issue side behaves. Op code 3 never arrives on a valid lane. Tags in flight are unique and do not wrap while they are in the pool. The three latencies are distinct, so no more than three issue bursts can finish together and the port width of three times `ISSUE_W` is enough. The stimulus issues at most `ISSUE_W` instructions per cycle and gives every instruction a fresh tag below 256 that is never reused. It uses only op codes 0 to 2. In one cycle it deliberately issues tags in descending lane order, so that the sort and not the lane position sets the output order.

// File: rtl/epool_pkg.sv
package epool_pkg;

  localparam int ISSUE_W   = 2;
  localparam int TAG_W     = 8;
  localparam int REG_W     = 7;
  localparam int LAT_SHORT = 1;
  localparam int LAT_MID   = 2;
  localparam int LAT_LONG  = 10;

  localparam int SLOTS  = ISSUE_W * LAT_LONG;
  localparam int CMP_W  = 3 * ISSUE_W;
  localparam int CNT_W  = $clog2(LAT_LONG + 1);
  localparam int LANE_W = (ISSUE_W > 1) ? $clog2(ISSUE_W) : 1;
  localparam int RANK_W = $clog2(SLOTS + 1);

  typedef enum logic [1:0] {
    OP_SHORT = 2'd0,
    OP_MID   = 2'd1,
    OP_LONG  = 2'd2,
    OP_RSVD  = 2'd3
  } opKind_e;

  // Strobes from allocation control to the slot datapath.
  typedef struct packed {
    logic [SLOTS-1:0]             loadEn;
    logic [SLOTS-1:0][LANE_W-1:0] loadSel;
  } slotStrobe_t;

  function automatic logic [CNT_W-1:0] opLatency(input logic [1:0] op);
    case (op)
      OP_SHORT: opLatency = CNT_W'(LAT_SHORT);
      OP_MID:   opLatency = CNT_W'(LAT_MID);
      default:  opLatency = CNT_W'(LAT_LONG);
    endcase
  endfunction

endpackage

// File: rtl/epool_ctrl.sv
module epool_ctrl
  import epool_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [ISSUE_W-1:0] issueValid,
  input  logic [SLOTS-1:0]   slotValid,
  input  logic [SLOTS-1:0]   slotDone,
  output slotStrobe_t        stb
);

  logic [SLOTS-1:0]   slotFree;
  logic [SLOTS-1:0]   taken;
  logic [ISSUE_W-1:0] laneGot;

  assign slotFree = ~slotValid | slotDone;

  // Each valid lane, in lane order, claims the lowest free slot not yet taken.
  always_comb begin
    taken   = '0;
    laneGot = '0;
    stb     = '0;
    for (int l = 0; l < ISSUE_W; l++) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (issueValid[l] && !laneGot[l] && slotFree[s] && !taken[s]) begin
          taken[s]       = 1'b1;
          laneGot[l]     = 1'b1;
          stb.loadEn[s]  = 1'b1;
          stb.loadSel[s] = LANE_W'(l);
        end
      end
    end
  end

  // R5: every valid issue lane finds a slot
  a_r5_lane_placed: assert property (@(posedge clk) disable iff (rst)
    (issueValid & ~laneGot) == '0);

  // R5: occupancy after the edge never exceeds the pool
  a_r5_pool_bound: assert property (@(posedge clk) disable iff (rst)
    ($countones(slotValid & ~slotDone) + $countones(issueValid)) <= SLOTS);

  // R5: the number of loaded slots matches the number of valid lanes
  a_r5_load_count: assert property (@(posedge clk) disable iff (rst)
    $countones(stb.loadEn) == $countones(issueValid));

endmodule

// File: rtl/epool_slots.sv
module epool_slots
  import epool_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  slotStrobe_t              stb,
  input  logic [ISSUE_W-1:0]       issueValid,
  input  logic [2*ISSUE_W-1:0]     issueOp,
  input  logic [ISSUE_W*TAG_W-1:0] issueTag,
  input  logic [ISSUE_W*REG_W-1:0] issueDest,
  input  logic [ISSUE_W-1:0]       issueHasDest,
  output logic [SLOTS-1:0]         slotValid,
  output logic [SLOTS-1:0]         slotDone,
  output logic [SLOTS-1:0]         slotHasDest,
  output logic [SLOTS*TAG_W-1:0]   slotTag,
  output logic [SLOTS*REG_W-1:0]   slotDest
);

  logic [SLOTS-1:0] valid;
  logic [SLOTS-1:0] hdQ;
  logic [CNT_W-1:0] remain [SLOTS];
  logic [TAG_W-1:0] tagQ   [SLOTS];
  logic [REG_W-1:0] destQ  [SLOTS];

  logic [1:0]       loadOp   [SLOTS];
  logic [TAG_W-1:0] loadTag  [SLOTS];
  logic [REG_W-1:0] loadDest [SLOTS];
  logic [SLOTS-1:0] loadHd;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign loadOp[s]   = issueOp[int'(stb.loadSel[s])*2 +: 2];
    assign loadTag[s]  = issueTag[int'(stb.loadSel[s])*TAG_W +: TAG_W];
    assign loadDest[s] = issueDest[int'(stb.loadSel[s])*REG_W +: REG_W];
    assign loadHd[s]   = issueHasDest[stb.loadSel[s]];

    assign slotDone[s]                  = valid[s] && (remain[s] == CNT_W'(1));
    assign slotTag[s*TAG_W +: TAG_W]    = tagQ[s];
    assign slotDest[s*REG_W +: REG_W]   = destQ[s];

    // R4: a live counter is never zero and never above the longest latency
    a_r4_count_range: assert property (@(posedge clk) disable iff (rst)
      valid[s] |-> (remain[s] != '0) && (remain[s] <= CNT_W'(LAT_LONG)));

    // R6: a finishing slot that is not reloaded is empty afterwards
    a_r6_slot_freed: assert property (@(posedge clk) disable iff (rst)
      (slotDone[s] && !stb.loadEn[s]) |=> !slotValid[s]);

    // R2: a short op finishes in the cycle right after its load
    a_r2_short_lat: assert property (@(posedge clk) disable iff (rst)
      (stb.loadEn[s] && loadOp[s] == OP_SHORT) |=> slotDone[s]);

    // R3: a mid op is not done after one edge and is done after two
    a_r3_mid_lat: assert property (@(posedge clk) disable iff (rst)
      (stb.loadEn[s] && loadOp[s] == OP_MID) |=> !slotDone[s] ##1 slotDone[s]);
  end

  assign slotValid   = valid;
  assign slotHasDest = hdQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= '0;
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (stb.loadEn[s]) begin
          valid[s]  <= 1'b1;
          remain[s] <= opLatency(loadOp[s]);
          tagQ[s]   <= loadTag[s];
          destQ[s]  <= loadDest[s];
          hdQ[s]    <= loadHd[s];
        end else if (slotDone[s]) begin
          valid[s]  <= 1'b0;
        end else if (valid[s]) begin
          remain[s] <= remain[s] - CNT_W'(1);
        end
      end
    end
  end

  // Input contract: op code 3 is never issued
  for (genvar l = 0; l < ISSUE_W; l++) begin : g_lane
    a_r4_op_legal: assert property (@(posedge clk) disable iff (rst)
      issueValid[l] |-> (issueOp[2*l +: 2] != OP_RSVD));
  end

endmodule

// File: rtl/epool_order.sv
module epool_order
  import epool_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [SLOTS-1:0]       slotDone,
  input  logic [SLOTS-1:0]       slotHasDest,
  input  logic [SLOTS*TAG_W-1:0] slotTag,
  input  logic [SLOTS*REG_W-1:0] slotDest,
  output logic [CMP_W-1:0]       doneValid,
  output logic [CMP_W*TAG_W-1:0] doneTag,
  output logic [CMP_W*REG_W-1:0] doneDest
);

  logic [SLOTS-1:0]  bcast;
  logic [RANK_W-1:0] rank [SLOTS];

  assign bcast = slotDone & slotHasDest;

  // Rank of a broadcasting slot = number of broadcasting slots with a smaller tag.
  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      rank[i] = '0;
      for (int j = 0; j < SLOTS; j++) begin
        if (bcast[j] && (slotTag[j*TAG_W +: TAG_W] < slotTag[i*TAG_W +: TAG_W])) begin
          rank[i] = rank[i] + RANK_W'(1);
        end
      end
    end
  end

  // Scatter each broadcasting slot onto the lane named by its rank.
  always_comb begin
    doneValid = '0;
    doneTag   = '0;
    doneDest  = '0;
    for (int i = 0; i < SLOTS; i++) begin
      for (int r = 0; r < CMP_W; r++) begin
        if (bcast[i] && rank[i] == RANK_W'(r)) begin
          doneValid[r]                = 1'b1;
          doneTag[r*TAG_W +: TAG_W]   = slotTag[i*TAG_W +: TAG_W];
          doneDest[r*REG_W +: REG_W]  = slotDest[i*REG_W +: REG_W];
        end
      end
    end
  end

  // R7: completions in one cycle fit the port
  a_r7_port_fits: assert property (@(posedge clk) disable iff (rst)
    $countones(bcast) <= CMP_W);

  // R6: every broadcasting slot shows up on exactly one lane, silent ones on none
  a_r6_lane_count: assert property (@(posedge clk) disable iff (rst)
    $countones(doneValid) == $countones(bcast));

  for (genvar r = 1; r < CMP_W; r++) begin : g_lane
    // R7: lanes packed from zero, tags strictly ascending
    a_r7_ascending: assert property (@(posedge clk) disable iff (rst)
      doneValid[r] |-> doneValid[r-1] &&
        (doneTag[(r-1)*TAG_W +: TAG_W] < doneTag[r*TAG_W +: TAG_W]));
  end

endmodule

// File: rtl/epool_top.sv
module epool_top
  import epool_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ISSUE_W-1:0]       issueValid,
  input  logic [2*ISSUE_W-1:0]     issueOp,
  input  logic [ISSUE_W*TAG_W-1:0] issueTag,
  input  logic [ISSUE_W*REG_W-1:0] issueDest,
  input  logic [ISSUE_W-1:0]       issueHasDest,
  output logic [CMP_W-1:0]         doneValid,
  output logic [CMP_W*TAG_W-1:0]   doneTag,
  output logic [CMP_W*REG_W-1:0]   doneDest
);

  slotStrobe_t            stb;
  logic [SLOTS-1:0]       slotValid;
  logic [SLOTS-1:0]       slotDone;
  logic [SLOTS-1:0]       slotHasDest;
  logic [SLOTS*TAG_W-1:0] slotTag;
  logic [SLOTS*REG_W-1:0] slotDest;

  epool_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .issueValid (issueValid),
    .slotValid  (slotValid),
    .slotDone   (slotDone),
    .stb        (stb)
  );

  epool_slots u_slots (
    .clk          (clk),
    .rst          (rst),
    .stb          (stb),
    .issueValid   (issueValid),
    .issueOp      (issueOp),
    .issueTag     (issueTag),
    .issueDest    (issueDest),
    .issueHasDest (issueHasDest),
    .slotValid    (slotValid),
    .slotDone     (slotDone),
    .slotHasDest  (slotHasDest),
    .slotTag      (slotTag),
    .slotDest     (slotDest)
  );

  epool_order u_order (
    .clk         (clk),
    .rst         (rst),
    .slotDone    (slotDone),
    .slotHasDest (slotHasDest),
    .slotTag     (slotTag),
    .slotDest    (slotDest),
    .doneValid   (doneValid),
    .doneTag     (doneTag),
    .doneDest    (doneDest)
  );

endmodule

// File: tb/tb_epool_top.sv
module tb_epool_top;
  import epool_pkg::*;

  typedef struct packed {
    logic             v;
    logic [1:0]       op;
    logic [TAG_W-1:0] tag;
    logic [REG_W-1:0] dest;
    logic             hd;
  } laneStim_t;
  typedef laneStim_t [ISSUE_W-1:0] rowStim_t;

  function automatic laneStim_t mk(input int v, input int op, input int tag,
                                   input int dest, input int hd);
    mk.v = v[0]; mk.op = op[1:0]; mk.tag = tag[TAG_W-1:0];
    mk.dest = dest[REG_W-1:0]; mk.hd = hd[0];
  endfunction

  localparam laneStim_t NONE = '0;
  localparam int NROWS = 16;
  // Each row is {lane1, lane0}.
  localparam rowStim_t STIM [NROWS] = '{
    {NONE,                 mk(1, 0,  1,  3, 1)},
    {mk(1, 0,  3,  5, 1),  mk(1, 1,  2,  4, 1)},
    {mk(1, 1,  5,  7, 1),  mk(1, 2,  4,  6, 1)},
    {mk(1, 2,  7,  9, 0),  mk(1, 0,  6,  8, 1)},
    {NONE,                 NONE},
    {mk(1, 2, 20, 11, 1),  mk(1, 2, 40, 10, 1)},
    {mk(1, 0,  8, 13, 0),  mk(1, 1,  9, 12, 1)},
    {mk(1, 1, 11, 15, 1),  mk(1, 0, 10, 14, 1)},
    {NONE,                 NONE},
    {NONE,                 NONE},
    {mk(1, 1, 15, 21, 1),  NONE},
    {NONE,                 NONE},
    {NONE,                 NONE},
    {mk(1, 1, 12, 17, 1),  mk(1, 1, 30, 16, 1)},
    {mk(1, 0, 13, 19, 1),  mk(1, 0, 50, 18, 1)},
    {NONE,                 NONE}
  };

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic [ISSUE_W-1:0]       issueValid = '0;
  logic [2*ISSUE_W-1:0]     issueOp = '0;
  logic [ISSUE_W*TAG_W-1:0] issueTag = '0;
  logic [ISSUE_W*REG_W-1:0] issueDest = '0;
  logic [ISSUE_W-1:0]       issueHasDest = '0;
  logic [CMP_W-1:0]         doneValid;
  logic [CMP_W*TAG_W-1:0]   doneTag;
  logic [CMP_W*REG_W-1:0]   doneDest;

  epool_top dut (
    .clk(clk), .rst(rst), .issueValid(issueValid), .issueOp(issueOp),
    .issueTag(issueTag), .issueDest(issueDest), .issueHasDest(issueHasDest),
    .doneValid(doneValid), .doneTag(doneTag), .doneDest(doneDest)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int mCnt   = 0;
  int mTag [256];
  int mDest[256];
  int mOp  [256];
  int mHd  [256];
  int mCyc [256];

  function automatic int benchLat(input int op);
    if (op == 0) return 1;
    if (op == 1) return 2;
    return 10;
  endfunction

  // Compare the port against the reference list of records due this cycle.
  task automatic checkOut(input string req);
    int idx[16];
    int n;
    logic [CMP_W-1:0]       expV;
    logic [CMP_W*TAG_W-1:0] expT;
    logic [CMP_W*REG_W-1:0] expD;
    n = 0;
    for (int i = 0; i < mCnt; i++) begin
      if (mHd[i] != 0 && mCyc[i] + benchLat(mOp[i]) == cyc && n < 16) begin
        idx[n] = i;
        n++;
      end
    end
    for (int a = 0; a < n; a++) begin
      for (int b = a + 1; b < n; b++) begin
        if (mTag[idx[b]] < mTag[idx[a]]) begin
          int t;
          t = idx[a]; idx[a] = idx[b]; idx[b] = t;
        end
      end
    end
    expV = '0; expT = '0; expD = '0;
    for (int k = 0; k < n && k < CMP_W; k++) begin
      expV[k] = 1'b1;
      expT[k*TAG_W +: TAG_W] = mTag[idx[k]][TAG_W-1:0];
      expD[k*REG_W +: REG_W] = mDest[idx[k]][REG_W-1:0];
    end
    checks++;
    if (doneValid !== expV || doneTag !== expT || doneDest !== expD) begin
      fails++;
      $display("FAIL %s cycle %0d: act v=%b t=%h d=%h exp v=%b t=%h d=%h",
               req, cyc, doneValid, doneTag, doneDest, expV, expT, expD);
    end
  endtask

  task automatic step(input rowStim_t r, input string req);
    @(negedge clk);
    checkOut(req);
    for (int l = 0; l < ISSUE_W; l++) begin
      issueValid[l]                  = r[l].v;
      issueOp[2*l +: 2]              = r[l].op;
      issueTag[l*TAG_W +: TAG_W]     = r[l].tag;
      issueDest[l*REG_W +: REG_W]    = r[l].dest;
      issueHasDest[l]                = r[l].hd;
      if (r[l].v) begin
        mTag[mCnt] = int'(r[l].tag); mDest[mCnt] = int'(r[l].dest);
        mOp[mCnt] = int'(r[l].op);   mHd[mCnt] = int'(r[l].hd);
        mCyc[mCnt] = cyc;
        mCnt++;
      end
    end
    cyc++;
  endtask

  task automatic checkQuiet(input string req);
    checks++;
    if (doneValid !== '0) begin
      fails++;
      $display("FAIL %s: act doneValid=%b exp doneValid=%b", req, doneValid, {CMP_W{1'b0}});
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int tg;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkQuiet("R1 during reset");
    rst = 1'b0;

    // Table walk: R2 R3 R4 R7 R8 R9 (mixed latencies, same-cycle sort, lane reversal)
    for (int i = 0; i < NROWS; i++) step(STIM[i], "R2 R3 R4 R7 R8 R9");
    for (int i = 0; i < 12; i++) step({NONE, NONE}, "R2 R3 R4 R7 R8 R9 drain");

    // R6: fill the pool with silent long ops, then keep issuing long ops with a destination
    tg = 60;
    for (int i = 0; i < 10; i++) begin
      step({mk(1, 2, tg + 1, i + 30, 0), mk(1, 2, tg, i + 40, 0)}, "R6 silent fill");
      tg += 2;
    end
    // R5: continuous full-width long ops while slots recycle
    for (int i = 0; i < 14; i++) begin
      step({mk(1, 2, tg + 1, i + 60, 1), mk(1, 2, tg, i + 80, 1)}, "R5 R6 full rate");
      tg += 2;
    end
    for (int i = 0; i < 12; i++) step({NONE, NONE}, "R5 drain");

    // R1: reset while work is in flight drops it
    step({mk(1, 2, 201, 5, 1), mk(1, 0, 200, 4, 1)}, "R1 pre-reset");
    step({NONE, mk(1, 1, 202, 6, 1)}, "R1 pre-reset");
    @(negedge clk);
    rst = 1'b1;
    issueValid = '0;
    @(negedge clk);
    checkQuiet("R1 reset mid-run");
    rst = 1'b0;
    mCnt = 0;
    cyc += 2;
    for (int i = 0; i < 12; i++) step({NONE, NONE}, "R1 after reset");

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule